// File: doc/BRIEF.md
# SAR Converter Serial Readout Port

This block models the digital side of a successive-approximation converter that is read over a three-wire serial link with a chip-select style strobe. A rising edge on the convert strobe starts a conversion of fixed length, counted in system clocks, and floats the serial data output at once. Once started, the conversion ignores the strobe until its count runs out. At the end of the count the block captures the parallel sample input into its shift register and enters the acquisition phase.

The host reads the result by holding the strobe low after the conversion has ended: the most significant bit then appears on the output, and each falling edge of the serial clock presents the next bit. The output floats again on the last falling clock edge of the word, or earlier if the strobe rises, which also starts the next conversion. The strobe and serial clock are taken as synchronous to the system clock; the output is modelled as a data bit plus an output enable so the floating state is visible.

Top module: `sar_serial_port`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the output enable `sdoEn` is 0.
- R2: When `convStrobe` is sampled high after being sampled low (outside a conversion), `sdoEn` is 0 from the next clock edge and a conversion starts.
- R3: A conversion lasts CONV_CYCLES clocks; `sampleIn` is captured on the clock edge that ends it, CONV_CYCLES edges after the edge that saw the strobe rise, and later changes of `sampleIn` do not affect the word being read.
- R4: During a conversion the strobe is ignored: a low strobe does not enable the output, and a second rising edge does not restart or lengthen the conversion.
- R5: After a conversion has ended, the first clock edge that samples `convStrobe` low sets `sdoEn` to 1 with `sdoData` equal to bit DATA_W-1 of the captured word.
- R6: While `sdoEn` is 1, each falling edge of `serClk` (sampled 1 then 0) presents the next lower bit, so after k falling edges `sdoData` equals bit DATA_W-1-k; without a falling edge `sdoData` holds.
- R7: The DATA_W-th falling edge of `serClk` sets `sdoEn` to 0, and the output stays off, whatever the clock and a low strobe do, until a new conversion has ended.
- R8: Falling edges of `serClk` while `sdoEn` is 0 do not shift the captured word.
- R9: A rising strobe while the word is being read sets `sdoEn` to 0 on the next edge, before the word is complete, and starts a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStrobe | input | 1 | Convert strobe / chip select from the host |
| serClk | input | 1 | Serial clock from the host |
| sampleIn | input | DATA_W | Parallel result of the analog conversion |
| sdoData | output | 1 | Serial data value |
| sdoEn | output | 1 | Serial data output enable (0 = high impedance) |

## Verification
A wrong conversion count shows as an output enable one or more cycles away from the edge CONV_CYCLES+1 after the strobe rose with the strobe already low, so the bench checks the enable on both sides of that exact cycle. A bit counter or shift register that is off by one shows within the first few serial clock falls as a wrong bit, or at the end of the word as an enable that drops one fall early or late. A readiness flag left set after a read would re-enable the output with a stale word on the next cycle with the strobe low, which the bench looks for right after the last bit and after an interrupted read.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;

  typedef enum logic {
    ST_ACQ  = 1'b0,
    ST_CONV = 1'b1
  } portState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } dpCtl_t;

endpackage

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
  import sar_serial_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   convStrobe,
  input  logic   serClk,
  output dpCtl_t dpCtl,
  output logic   sdoEn
);

  localparam int CNT_W  = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  portState_t       state;
  logic [CNT_W-1:0] convCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             strobeQ;
  logic             clkQ;
  logic             wordReady;
  logic             enR;

  logic strobeRise;
  logic serFall;
  logic convDone;
  logic lastFall;

  assign strobeRise = convStrobe && !strobeQ;
  assign serFall    = !serClk && clkQ;
  assign convDone   = (state == ST_CONV) && (convCnt == CNT_LAST);
  assign lastFall   = enR && serFall && (bitCnt == BIT_LAST);

  always_comb begin
    dpCtl.load  = convDone;
    dpCtl.shift = (state == ST_ACQ) && !strobeRise && enR && serFall && !lastFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ACQ;
      convCnt   <= '0;
      bitCnt    <= '0;
      strobeQ   <= 1'b1;
      clkQ      <= 1'b0;
      wordReady <= 1'b0;
      enR       <= 1'b0;
    end else begin
      strobeQ <= convStrobe;
      clkQ    <= serClk;
      unique case (state)
        ST_CONV: begin
          if (convDone) begin
            state     <= ST_ACQ;
            wordReady <= 1'b1;
          end else begin
            convCnt <= convCnt + 1'b1;
          end
        end
        ST_ACQ: begin
          if (strobeRise) begin
            state     <= ST_CONV;
            convCnt   <= '0;
            enR       <= 1'b0;
            wordReady <= 1'b0;
          end else if (enR) begin
            if (serFall) begin
              if (lastFall) enR <= 1'b0;
              else bitCnt <= bitCnt + 1'b1;
            end
          end else if (wordReady && !convStrobe) begin
            enR       <= 1'b1;
            wordReady <= 1'b0;
            bitCnt    <= '0;
          end
        end
        default: state <= ST_ACQ;
      endcase
    end
  end

  assign sdoEn = enR;

endmodule

// File: rtl/sar_serial_datapath.sv
module sar_serial_datapath
  import sar_serial_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdoData
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (dpCtl.load) begin
      shiftReg <= sampleIn;
    end else if (dpCtl.shift) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  assign sdoData = shiftReg[DATA_W-1];

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
  import sar_serial_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStrobe,
  input  logic              serClk,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdoData,
  output logic              sdoEn
);

  dpCtl_t dpCtl;

  sar_serial_ctrl #(
    .DATA_W     (DATA_W),
    .CONV_CYCLES(CONV_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .convStrobe(convStrobe),
    .serClk    (serClk),
    .dpCtl     (dpCtl),
    .sdoEn     (sdoEn)
  );

  sar_serial_datapath #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .sampleIn(sampleIn),
    .sdoData (sdoData)
  );

endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40
) (
  input logic clk,
  input logic rstN,
  input logic convStrobe,
  input logic serClk,
  input logic sdoData,
  input logic sdoEn
);

  localparam int CW = $clog2(CONV_CYCLES + 2);
  localparam int FW = $clog2(DATA_W + 1);

  logic          strobeD;
  logic          clkD;
  logic [CW-1:0] convLeft;
  logic [FW-1:0] fallCnt;
  logic          seenFall;

  assign seenFall = !serClk && clkD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeD  <= 1'b1;
      clkD     <= 1'b0;
      convLeft <= '0;
      fallCnt  <= '0;
    end else begin
      strobeD <= convStrobe;
      clkD    <= serClk;
      if (convLeft != '0) convLeft <= convLeft - 1'b1;
      else if (convStrobe && !strobeD) convLeft <= CW'(CONV_CYCLES);
      if (!sdoEn) fallCnt <= '0;
      else if (seenFall) fallCnt <= fallCnt + 1'b1;
    end
  end

  // R2: a strobe rise outside a conversion floats the output on the next edge
  a_r2_rise_floats: assert property (@(posedge clk) disable iff (!rstN)
    (convStrobe && !strobeD && convLeft == '0) |=> !sdoEn);

  // R4: no drive while a conversion is running
  a_r4_quiet_in_conv: assert property (@(posedge clk) disable iff (!rstN)
    (convLeft != '0) |-> !sdoEn);

  // R5: the output turns on only after an edge that saw the strobe low
  a_r5_enable_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdoEn) |-> !$past(convStrobe));

  // R6: without a clock fall the presented bit holds
  a_r6_hold_bit: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && $past(sdoEn) && !$past(seenFall)) |-> $stable(sdoData));

  // R7: the last fall of the word releases the output
  a_r7_release_last: assert property (@(posedge clk) disable iff (!rstN)
    (sdoEn && seenFall && fallCnt == FW'(DATA_W - 1)) |=> !sdoEn);

endmodule

bind sar_serial_port sar_serial_port_chk #(
  .DATA_W     (DATA_W),
  .CONV_CYCLES(CONV_CYCLES)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .convStrobe(convStrobe),
  .serClk    (serClk),
  .sdoData   (sdoData),
  .sdoEn     (sdoEn)
);

// File: tb/sar_serial_port_tb.sv
`timescale 1ns/1ps
module sar_serial_port_tb_top;

  localparam int DATA_W = 16;
  localparam int CONV_CYCLES = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convStrobe = 1'b0;
  logic serClk = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic sdoData;
  logic sdoEn;

  int vecCnt = 0;
  int missCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sar_serial_port #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) dut_i (
    .clk(clk), .rstN(rstN), .convStrobe(convStrobe), .serClk(serClk),
    .sampleIn(sampleIn), .sdoData(sdoData), .sdoEn(sdoEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sckPulse();
    @(negedge clk) serClk = 1'b1;
    @(negedge clk) serClk = 1'b0;
    @(negedge clk);
  endtask

  // raise strobe and wait until the conversion has ended, strobe still high
  task automatic convert();
    @(negedge clk) convStrobe = 1'b1;
    nclk(1);
    chk("R2 rise floats output", sdoEn, 0);
    nclk(CONV_CYCLES + 1);
  endtask

  // lower strobe and read the whole word
  task automatic readWord(input logic [DATA_W-1:0] w, input string tag);
    convStrobe = 1'b0;
    nclk(1);
    chk({tag, " R5 enable"}, sdoEn, 1);
    chk({tag, " R5 msb"}, sdoData, w[DATA_W-1]);
    for (int k = 1; k < DATA_W; k++) begin
      sckPulse();
      chk({tag, " R6 bit"}, {sdoEn, sdoData}, {1'b1, w[DATA_W-1-k]});
    end
    sckPulse();
    chk({tag, " R7 release after last fall"}, sdoEn, 0);
  endtask

  task automatic tReset();
    chk("R1 in reset", sdoEn, 0);
    @(negedge clk) rstN = 1'b1;
    nclk(1);
    chk("R1 after reset", sdoEn, 0);
  endtask

  task automatic tBasic();
    sampleIn = 16'hA5C3;
    convert();
    readWord(16'hA5C3, "basic");
    sampleIn = 16'h8001;
    convert();
    readWord(16'h8001, "pattern2");
  endtask

  task automatic tTiming();
    // R3 capture at end of count; R4 low strobe ignored in conversion
    sampleIn = 16'h1234;
    @(negedge clk) convStrobe = 1'b1;
    nclk(3);
    convStrobe = 1'b0;
    sampleIn = 16'h7FFE;
    nclk(CONV_CYCLES - 3);
    chk("R4 low strobe in conversion", sdoEn, 0);
    nclk(1);
    chk("R3 still off at completion edge", sdoEn, 0);
    sampleIn = 16'h0F0F;
    nclk(1);
    chk("R3 enable one edge after completion", sdoEn, 1);
    chk("R3 captured value msb", sdoData, 0);
    for (int k = 1; k < DATA_W; k++) begin
      sckPulse();
      chk("R3 captured value bit", sdoData, 1'((16'h7FFE >> (DATA_W-1-k)) & 1));
    end
    sckPulse();
    chk("R7 release", sdoEn, 0);
  endtask

  task automatic tRestartIgnored();
    sampleIn = 16'hC3A5;
    @(negedge clk) convStrobe = 1'b1;
    nclk(3);
    convStrobe = 1'b0;
    nclk(3);
    convStrobe = 1'b1;
    nclk(CONV_CYCLES - 5);
    convStrobe = 1'b0;
    nclk(1);
    chk("R4 second rise does not restart", sdoEn, 1);
    chk("R4 msb", sdoData, 1);
    for (int k = 1; k < DATA_W; k++) sckPulse();
    sckPulse();
    chk("R4 release", sdoEn, 0);
  endtask

  task automatic tAfterRelease();
    sampleIn = 16'h5A5A;
    convert();
    readWord(16'h5A5A, "again");
    for (int i = 0; i < 3; i++) sckPulse();
    nclk(4);
    chk("R7 stays off with strobe low", sdoEn, 0);
  endtask

  task automatic tIdleClocks();
    sampleIn = 16'h9C31;
    @(negedge clk) convStrobe = 1'b1;
    nclk(2);
    sckPulse();
    sckPulse();
    nclk(CONV_CYCLES);
    sckPulse();
    sckPulse();
    chk("R8 off while strobe high", sdoEn, 0);
    readWord(16'h9C31, "R8 idle clocks");
  endtask

  task automatic tAbort();
    sampleIn = 16'hF00D;
    convert();
    convStrobe = 1'b0;
    nclk(1);
    for (int i = 0; i < 5; i++) sckPulse();
    chk("R9 mid read bit", sdoData, 1'((16'hF00D >> (DATA_W-6)) & 1));
    convStrobe = 1'b1;
    sampleIn = 16'h0B0E;
    nclk(1);
    chk("R9 strobe rise releases", sdoEn, 0);
    nclk(CONV_CYCLES + 1);
    readWord(16'h0B0E, "R9 next word");
  endtask

  initial begin
    nclk(3);
    tReset();
    tBasic();
    tTiming();
    tRestartIgnored();
    tAfterRelease();
    tIdleClocks();
    tAbort();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      vecCnt++;
      missCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

endmodule